// File: doc/BRIEF.md
# Field memory initialization sequencer

This controller prepares a serial field memory, one with independent write and read address counters, for use after power is applied. Both counters are invalid at power-up. The controller holds them quiet until the supply has been good for a programmable stabilization interval. That interval is given in system clock cycles and should cover at least 100 microseconds. The controller then clocks the memory with a burst of dummy cycles and resets each pointer. Everything runs from one system clock. The controller gates two enables, one for the memory's write clock and one for its read clock. It also drives a one-cycle reset strobe for each pointer.

There are two initialization paths, and a mode input chooses between them. The controller samples the `supply_settled` input once, at the moment the sequence leaves its wait. If the supply was already settled, each side runs a dummy burst and then gives a single pointer reset. If the supply was not settled, each side gives a pointer reset, then runs the dummy burst, then gives a second pointer reset. The write side and the read side run in lockstep. `init_done` rises only once both sides have finished. Until then, no functional access may be made to the memory. If the supply drops at any point, the whole sequence is abandoned and begins again from the wait.

Top module: `fmem_init_seq`

## Requirements
- R1: While `rst_n` is low, all five outputs are 0.
- R2: No enable or reset strobe is driven until `supply_ok` has been 1 on WAIT_CYCLES consecutive clock edges. The first activity appears in the cycle after the edge that completes that count, so its first output cycle comes WAIT_CYCLES+1 edges after `supply_ok` was first seen high.
- R3: In the settled path (`supply_settled`=1 at start), each side's clock enable is high for exactly DUMMY_CYCLES consecutive cycles. The matching pointer reset strobe follows in the next cycle.
- R4: In the unsettled path (`supply_settled`=0 at start), each side drives the order reset strobe, then DUMMY_CYCLES enable cycles, then a second reset strobe, with no gaps between these phases.
- R5: The write side and the read side run in parallel. In every cycle, `wclk_en` equals `rclk_en` and `wptr_rst` equals `rptr_rst`.
- R6: Every reset strobe is exactly one clock wide, and the clock enable of the same side is low while its strobe is high.
- R7: `init_done` rises two cycles after the final reset strobe of both sides. It then stays high while `supply_ok` stays 1, and no enable or strobe is driven while it is high.
- R8: After any edge that sees `supply_ok`=0, all outputs are 0 in the following cycle, `init_done` included. When `supply_ok` returns, the full sequence restarts with a fresh wait.
- R9: `supply_settled` is sampled only when the sequence leaves the wait. Changing it afterwards does not change the path being run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication; 0 aborts the sequence |
| supply_settled | input | 1 | 1 when the supply was settled as the dummy cycles start (picks the short path) |
| wclk_en | output | 1 | Gate enable for the memory write clock (dummy write cycles) |
| rclk_en | output | 1 | Gate enable for the memory read clock (dummy read cycles) |
| wptr_rst | output | 1 | One-cycle write-pointer reset strobe |
| rptr_rst | output | 1 | One-cycle read-pointer reset strobe |
| init_done | output | 1 | Pointers valid; functional access allowed |

## Verification
Two functions can land in the same cycle: the supply abort, and the final pointer reset strobe that would otherwise lead to `init_done`. The bench provokes this by running a settled-path sequence up to the cycle where the final strobe is visible. It then drops `supply_ok` during that same cycle. The result is judged at the ports. All outputs must be 0 from the next cycle on, and `init_done` must never rise, even though the strobe has already been issued. A second overlap is checked in every cycle of every trace: the write and read strobes fire together, as do the two enables.

// File: rtl/fmem_init_pkg.sv
// Package: shared constants and the per-side state type of the
// field memory initialization sequencer.
package fmem_init_pkg;

    localparam int NUM_SIDES = 2;   // one write side, one read side
    localparam int SIDE_WR   = 0;
    localparam int SIDE_RD   = 1;

    typedef enum logic [2:0] {
        SD_IDLE = 3'd0,   // waiting for the stabilization interval
        SD_PRE  = 3'd1,   // leading pointer reset (unsettled path only)
        SD_BURST = 3'd2,  // dummy clock enables
        SD_POST = 3'd3,   // final pointer reset
        SD_DONE = 3'd4    // side finished
    } side_state_t;

endpackage

// File: rtl/fmem_stab_timer.sv
// Module: fmem_stab_timer
// Counts consecutive cycles of supply-good. Once WAIT_CYCLES edges have
// seen supply_ok high, ready is raised and held. Any low cycle clears the
// count and ready.
// Assumes WAIT_CYCLES >= 1 and supply_ok synchronous to clk.
module fmem_stab_timer #(
    parameter int WAIT_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic ready
);
    localparam int TW = $clog2(WAIT_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    // Saturating stabilization counter and sticky ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else begin
            if (cnt_q != TW'(WAIT_CYCLES))
                cnt_q <= cnt_q + 1'b1;
            if (cnt_q == TW'(WAIT_CYCLES - 1))
                ready <= 1'b1;
        end
    end

endmodule

// File: rtl/fmem_side_seq.sv
// Module: fmem_side_seq
// Sequences one pointer side (write or read) of the field memory: an
// optional leading reset strobe, a burst of dummy clock enables, then a
// final reset strobe. The path is latched when start is first seen in
// idle. abort returns the side to idle from any state.
// Assumes DUMMY_CYCLES >= 1.
module fmem_side_seq
    import fmem_init_pkg::*;
#(
    parameter int DUMMY_CYCLES = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    input  logic long_mode,
    output logic clk_en,
    output logic ptr_rst,
    output logic side_done
);
    localparam int CW = $clog2(DUMMY_CYCLES + 1);

    side_state_t   state_q;
    logic [CW-1:0] cnt_q;

    // Side state machine with saturating dummy-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state_q <= SD_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SD_IDLE: begin
                    cnt_q <= '0;
                    if (start)
                        state_q <= long_mode ? SD_PRE : SD_BURST;
                end
                SD_PRE:   state_q <= SD_BURST;
                SD_BURST: begin
                    if (cnt_q >= CW'(DUMMY_CYCLES - 1))
                        state_q <= SD_POST;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                SD_POST:  state_q <= SD_DONE;
                SD_DONE:  state_q <= SD_DONE;
                default:  state_q <= SD_IDLE;
            endcase
        end
    end

    // Output decode from state.
    always_comb begin
        clk_en    = (state_q == SD_BURST);
        ptr_rst   = (state_q == SD_PRE) || (state_q == SD_POST);
        side_done = (state_q == SD_DONE);
    end

endmodule

// File: rtl/fmem_init_seq.sv
// Module: fmem_init_seq (top)
// Power-up initialization sequencer for a field memory with separate write
// and read address counters. It waits for the supply to be stable, then
// runs identical write and read side sequences in parallel, and flags
// completion once both sides are finished.
// Assumes supply_ok and supply_settled are synchronous to clk.
module fmem_init_seq
    import fmem_init_pkg::*;
#(
    parameter int WAIT_CYCLES  = 5000,
    parameter int DUMMY_CYCLES = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic supply_settled,
    output logic wclk_en,
    output logic rclk_en,
    output logic wptr_rst,
    output logic rptr_rst,
    output logic init_done
);
    logic                 stab_ready;
    logic [NUM_SIDES-1:0] side_en;
    logic [NUM_SIDES-1:0] side_rst;
    logic [NUM_SIDES-1:0] side_fin;
    logic                 done_q;

    fmem_stab_timer #(.WAIT_CYCLES(WAIT_CYCLES)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .ready     (stab_ready)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        fmem_side_seq #(.DUMMY_CYCLES(DUMMY_CYCLES)) i_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .abort     (!supply_ok),
            .start     (stab_ready),
            .long_mode (!supply_settled),
            .clk_en    (side_en[s]),
            .ptr_rst   (side_rst[s]),
            .side_done (side_fin[s])
        );
    end

    // Completion flag: both sides finished and the supply still good.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= supply_ok && (&side_fin);
    end

    assign wclk_en   = side_en[SIDE_WR];
    assign rclk_en   = side_en[SIDE_RD];
    assign wptr_rst  = side_rst[SIDE_WR];
    assign rptr_rst  = side_rst[SIDE_RD];
    assign init_done = done_q;

endmodule

// File: rtl/fmem_init_chk.sv
// Module: fmem_init_chk
// Port-level assertions for fmem_init_seq. Attached with bind below.
module fmem_init_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic wclk_en,
    input logic rclk_en,
    input logic wptr_rst,
    input logic rptr_rst,
    input logic init_done
);
    // R5: both sides move in lockstep.
    a_r5_sides_match: assert property (@(posedge clk) disable iff (!rst_n)
        (wclk_en == rclk_en) && (wptr_rst == rptr_rst));

    // R6: strobe is one cycle wide.
    a_r6_wrst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_rst |=> !wptr_rst);
    a_r6_rrst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rptr_rst |=> !rptr_rst);

    // R6: no dummy clock during a strobe.
    a_r6_no_en_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_rst |-> !wclk_en) and (rptr_rst |-> !rclk_en));

    // R7: done only after a final strobe, and quiet afterwards.
    a_r7_done_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(wptr_rst, 2) && $past(rptr_rst, 2));
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !wclk_en && !rclk_en && !wptr_rst && !rptr_rst);

    // R8: a supply drop clears everything on the next cycle.
    a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !init_done && !wclk_en && !rclk_en && !wptr_rst && !rptr_rst);

endmodule

bind fmem_init_seq fmem_init_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .wclk_en   (wclk_en),
    .rclk_en   (rclk_en),
    .wptr_rst  (wptr_rst),
    .rptr_rst  (rptr_rst),
    .init_done (init_done)
);

// File: tb/test_fmem_init_seq.sv
module test_fmem_init_seq;
    localparam int  W = 20;
    localparam int  D = 130;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, supply_ok, supply_settled;
    logic wclk_en, rclk_en, wptr_rst, rptr_rst, init_done;
    int   n_tests = 0;
    int   n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fmem_init_seq #(.WAIT_CYCLES(W), .DUMMY_CYCLES(D)) i_fmem_init_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .supply_settled(supply_settled), .wclk_en(wclk_en), .rclk_en(rclk_en),
        .wptr_rst(wptr_rst), .rptr_rst(rptr_rst), .init_done(init_done)
    );

    // Expected {en, rst, done} k edges after supply_ok was first raised.
    function automatic logic [2:0] expv(int k, bit lng);
        int s = W + 1;
        if (k < s) return 3'b000;
        if (!lng) begin
            if (k < s + D)      return 3'b100;
            if (k == s + D)     return 3'b010;
            if (k == s + D + 1) return 3'b000;
            return 3'b001;
        end
        if (k == s)             return 3'b010;
        if (k <= s + D)         return 3'b100;
        if (k == s + D + 1)     return 3'b010;
        if (k == s + D + 2)     return 3'b000;
        return 3'b001;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int k, bit lng);
        logic [2:0] e = expv(k, lng);
        logic [4:0] act = {wclk_en, rclk_en, wptr_rst, rptr_rst, init_done};
        logic [4:0] exp5 = {e[2], e[2], e[1], e[1], e[0]};
        n_tests++;
        if (act !== exp5) begin
            n_fail++;
            $display("FAIL %s k=%0d {wen,ren,wrst,rrst,done} actual=%b expected=%b",
                     req, k, act, exp5);
        end
    endtask

    // Runs a full trace from the raising of supply_ok; mode flipped mid-run.
    task automatic run_trace(string req, bit lng);
        supply_settled = !lng;
        supply_ok = 1'b1;
        for (int k = 1; k <= W + D + 6; k++) begin
            step();
            chk(req, k, lng);
            if (k == W + 3) supply_settled = lng;   // R9: ignored after start
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; supply_ok = 1'b1; supply_settled = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R1", 0, 1'b0);
        end
        supply_ok = 1'b0;
        step();
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R2 idle", 0, 1'b0);
        end
    endtask

    task automatic t_drop_after_done();
        supply_ok = 1'b0;
        step();
        chk("R8 drop", 0, 1'b0);
    endtask

    task automatic t_wait_glitch();
        supply_settled = 1'b1; supply_ok = 1'b1;
        for (int k = 1; k < W; k++) begin
            step();
            chk("R2 wait", k, 1'b0);
        end
        supply_ok = 1'b0;
        step();
        chk("R2 glitch", 0, 1'b0);
        run_trace("R2/R3 after glitch", 1'b0);
        t_drop_after_done();
    endtask

    task automatic t_mid_drop();
        supply_settled = 1'b1; supply_ok = 1'b1;
        for (int k = 1; k <= W + 10; k++) begin
            step();
            chk("R3 pre-drop", k, 1'b0);
        end
        supply_ok = 1'b0;
        for (int i = 0; i < 2; i++) begin
            step();
            chk("R8 mid-burst drop", 0, 1'b0);
        end
        run_trace("R8 restart", 1'b0);
        t_drop_after_done();
    endtask

    task automatic t_rst_drop();
        supply_settled = 1'b1; supply_ok = 1'b1;
        for (int k = 1; k <= W + D + 1; k++) begin
            step();
            chk("R6 pre-drop", k, 1'b0);
        end
        supply_ok = 1'b0;   // drop in the cycle of the final strobe
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R7/R8 drop at final strobe", 0, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run_trace("R3/R5/R6/R7/R9 settled", 1'b0);
        t_drop_after_done();
        run_trace("R4/R5/R6/R7/R9 unsettled", 1'b1);
        t_drop_after_done();
        t_wait_glitch();
        t_mid_drop();
        t_rst_drop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule